// File: doc/BRIEF.md
# Ping-Pong Packet Transmit Buffer

This block holds outgoing packets for a single packet endpoint in two equal halves of byte storage. A processor or a DMA engine pushes bytes through one 8-bit write port into whichever half is currently being filled. A packet-commit strobe seals the bytes gathered so far as one packet and moves filling to the other half. The link side can then send the sealed packet while the next one is assembled.

The link side reads the sealed packet one byte per read strobe and sees the packet length beside the data. It then reports the outcome of the transmission. An acknowledge frees the half for refilling and brings the next sealed packet, if one exists, to the read side. A failed attempt rewinds the read position so that the same bytes go out again from the first one. A clear strobe empties both halves at once.

Top module: `ppbuf_tx`

## Requirements
- R1: After reset, `empty_o` is 1, `rd_valid_o` is 0 and `ovf_o` is 0.
- R2: Bytes written while the fill half is not sealed are stored in write order. After a `commit_i` cycle, `rd_valid_o` is 1 from the next cycle while that packet is at the read side, and `rd_len_o` equals the number of bytes written. A write in the same cycle as `commit_i` belongs to the sealed packet.
- R3: `rd_data_o` shows the byte at the current read position. Each `rd_en_i` cycle with bytes remaining advances the position by one, so the bytes come out in write order.
- R4: A `commit_i` with no bytes written seals a zero-length packet: `rd_valid_o`=1, `rd_len_o`=0 and `rd_done_o`=1.
- R5: `nak_i` while a packet is at the read side returns the read position to its first byte, and the stored bytes are kept.
- R6: A sealed packet stays at the read side, with an unchanged length, until `ack_i`. After `ack_i`, the next sealed packet appears in the following cycle; if there is none, `rd_valid_o` drops to 0.
- R7: Packets are delivered in the order they were sealed, and one half can be filled while the other waits for acknowledgment.
- R8: While both halves are sealed, `empty_o` is 0, data-port writes are dropped and `commit_i` has no effect. `empty_o` is 1 whenever at least one half is free.
- R9: A half holds at most PKT_BYTES (64) bytes. Further writes to it are discarded and set `ovf_o`, which stays at 1 until `clr_i`.
- R10: `clr_i` empties both halves, clears `ovf_o` and resets the read position, so the next sealed packet starts from a clean state.
- R11: `rd_done_o` is 1 once all `rd_len_o` bytes have been read. Further `rd_en_i` strobes do not move the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Empty both halves |
| wr_en_i | input | 1 | Write strobe of the data port |
| wr_data_i | input | DATA_W | Byte to store |
| commit_i | input | 1 | Seal the fill half as one packet and swap halves |
| rd_en_i | input | 1 | Advance the read position by one byte |
| ack_i | input | 1 | Transmission acknowledged; free the half |
| nak_i | input | 1 | Transmission failed; rewind to the first byte |
| rd_valid_o | output | 1 | A sealed packet is at the read side |
| rd_data_o | output | DATA_W | Byte at the read position |
| rd_len_o | output | $clog2(PKT_BYTES+1) | Length of the packet at the read side |
| rd_done_o | output | 1 | All bytes of the current packet have been read |
| empty_o | output | 1 | At least one half is free for filling |
| ovf_o | output | 1 | A write was discarded because a half was full |

## Verification
A wrong fill-side pointer shows up as a length mismatch in the first cycle after the commit, or as bytes appearing in the wrong packet when that packet is drained. A wrong read pointer or half select shows up as a data mismatch on the next compared byte, and the scoreboard holds every expected byte in order to catch it. Broken full flags show up within one cycle as a wrong `empty_o` or `rd_valid_o`. The cycle after each drop, rewind or clear is checked against the queued expectation.

// File: rtl/ppbuf_pkg.sv
package ppbuf_pkg;
  localparam int unsigned NUM_HALVES = 2;

  typedef logic half_sel_t;

  typedef struct packed {
    logic      fire;
    half_sel_t sel;
  } release_t;
endpackage

// File: rtl/ppbuf_store.sv
module ppbuf_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              wsel_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rsel_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  import ppbuf_pkg::*;

  logic [DATA_W-1:0] bank_rd [NUM_HALVES];

  for (genvar b = 0; b < NUM_HALVES; b++) begin : g_bank
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && (wsel_i == 1'(b))) mem_q[waddr_i] <= wdata_i;
    end

    assign bank_rd[b] = mem_q[raddr_i];
  end

  assign rdata_o = bank_rd[rsel_i];
endmodule

// File: rtl/ppbuf_fill.sv
module ppbuf_fill #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  wr_en_i,
  input  logic                  commit_i,
  input  ppbuf_pkg::release_t   rel_i,
  output logic                  mem_we_o,
  output logic                  mem_wsel_o,
  output logic [AW-1:0]         mem_waddr_o,
  output logic [1:0]            full_o,
  output logic [1:0][CW-1:0]    cnt_o,
  output logic                  ovf_o
);
  import ppbuf_pkg::*;

  half_sel_t          fill_sel_q;
  logic [1:0]         full_q;
  logic [1:0][CW-1:0] cnt_q;
  logic               ovf_q;
  logic               cur_full;
  logic [CW-1:0]      cur_cnt;
  logic               wr_ok, wr_ovf, commit_ok;

  assign cur_full  = full_q[fill_sel_q];
  assign cur_cnt   = cnt_q[fill_sel_q];
  assign wr_ok     = wr_en_i && !cur_full && (cur_cnt < CW'(DEPTH));
  assign wr_ovf    = wr_en_i && !cur_full && (cur_cnt == CW'(DEPTH));
  assign commit_ok = commit_i && !cur_full;

  for (genvar b = 0; b < NUM_HALVES; b++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        full_q[b] <= 1'b0;
        cnt_q[b]  <= '0;
      end else if (clr_i) begin
        full_q[b] <= 1'b0;
        cnt_q[b]  <= '0;
      end else if (rel_i.fire && (rel_i.sel == 1'(b))) begin
        full_q[b] <= 1'b0;
        cnt_q[b]  <= '0;
      end else if (fill_sel_q == 1'(b)) begin
        if (wr_ok)     cnt_q[b]  <= cnt_q[b] + CW'(1);
        if (commit_ok) full_q[b] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_sel_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else if (clr_i) begin
      fill_sel_q <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      if (commit_ok) fill_sel_q <= ~fill_sel_q;
      if (wr_ovf)    ovf_q      <= 1'b1;
    end
  end

  assign mem_we_o    = wr_ok && !clr_i;
  assign mem_wsel_o  = fill_sel_q;
  assign mem_waddr_o = cur_cnt[AW-1:0];
  assign full_o      = full_q;
  assign cnt_o       = cnt_q;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/ppbuf_link.sv
module ppbuf_link #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                rd_en_i,
  input  logic                ack_i,
  input  logic                nak_i,
  input  logic [1:0]          full_i,
  input  logic [1:0][CW-1:0]  cnt_i,
  output logic                send_sel_o,
  output logic [AW-1:0]       raddr_o,
  output logic                rd_valid_o,
  output logic [CW-1:0]       rd_len_o,
  output logic                rd_done_o,
  output ppbuf_pkg::release_t rel_o
);
  import ppbuf_pkg::*;

  half_sel_t     send_sel_q;
  logic [CW-1:0] ptr_q;
  logic          valid;
  logic [CW-1:0] len;

  assign valid = full_i[send_sel_q];
  assign len   = cnt_i[send_sel_q];

  assign rel_o.fire = valid && ack_i && !clr_i;
  assign rel_o.sel  = send_sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      send_sel_q <= 1'b0;
      ptr_q      <= '0;
    end else if (clr_i) begin
      send_sel_q <= 1'b0;
      ptr_q      <= '0;
    end else if (rel_o.fire) begin
      send_sel_q <= ~send_sel_q;
      ptr_q      <= '0;
    end else if (valid && nak_i) begin
      ptr_q <= '0;
    end else if (valid && rd_en_i && (ptr_q < len)) begin
      ptr_q <= ptr_q + CW'(1);
    end
  end

  assign send_sel_o = send_sel_q;
  assign raddr_o    = ptr_q[AW-1:0];
  assign rd_valid_o = valid;
  assign rd_len_o   = len;
  assign rd_done_o  = valid && (ptr_q == len);
endmodule

// File: rtl/ppbuf_tx.sv
module ppbuf_tx #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned PKT_BYTES = 64,
  localparam int unsigned AW       = $clog2(PKT_BYTES),
  localparam int unsigned CW       = $clog2(PKT_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              rd_en_i,
  input  logic              ack_i,
  input  logic              nak_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CW-1:0]     rd_len_o,
  output logic              rd_done_o,
  output logic              empty_o,
  output logic              ovf_o
);
  import ppbuf_pkg::*;

  logic               mem_we, mem_wsel, send_sel;
  logic [AW-1:0]      mem_waddr, raddr;
  logic [1:0]         full;
  logic [1:0][CW-1:0] cnt;
  release_t           rel;

  ppbuf_fill #(.DEPTH(PKT_BYTES)) u_fill (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .wr_en_i    (wr_en_i),
    .commit_i   (commit_i),
    .rel_i      (rel),
    .mem_we_o   (mem_we),
    .mem_wsel_o (mem_wsel),
    .mem_waddr_o(mem_waddr),
    .full_o     (full),
    .cnt_o      (cnt),
    .ovf_o      (ovf_o)
  );

  ppbuf_link #(.DEPTH(PKT_BYTES)) u_link (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr_i),
    .rd_en_i   (rd_en_i),
    .ack_i     (ack_i),
    .nak_i     (nak_i),
    .full_i    (full),
    .cnt_i     (cnt),
    .send_sel_o(send_sel),
    .raddr_o   (raddr),
    .rd_valid_o(rd_valid_o),
    .rd_len_o  (rd_len_o),
    .rd_done_o (rd_done_o),
    .rel_o     (rel)
  );

  ppbuf_store #(.DATA_W(DATA_W), .DEPTH(PKT_BYTES)) u_store (
    .clk_i  (clk_i),
    .we_i   (mem_we),
    .wsel_i (mem_wsel),
    .waddr_i(mem_waddr),
    .wdata_i(wr_data_i),
    .rsel_i (send_sel),
    .raddr_i(raddr),
    .rdata_o(rd_data_o)
  );

  assign empty_o = ~&full;
endmodule

// File: rtl/ppbuf_tx_chk.sv
module ppbuf_tx_chk #(
  parameter int unsigned PKT_BYTES = 64,
  localparam int unsigned CW       = $clog2(PKT_BYTES + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          clr_i,
  input logic          commit_i,
  input logic          ack_i,
  input logic          nak_i,
  input logic          rd_valid_o,
  input logic [CW-1:0] rd_len_o,
  input logic          rd_done_o,
  input logic          empty_o,
  input logic          ovf_o
);
  assert_clear_state_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!rd_valid_o && empty_o && !ovf_o));

  assert_len_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> (rd_len_o <= CW'(PKT_BYTES)));

  assert_ovf_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_i) |=> ovf_o);

  assert_hold_until_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !ack_i && !clr_i) |=> (rd_valid_o && $stable(rd_len_o)));

  assert_commit_shows_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !rd_valid_o && !ack_i && !clr_i) |=> rd_valid_o);

  assert_nak_rewind_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nak_i && rd_valid_o && !ack_i && !clr_i) |=> (!rd_done_o || (rd_len_o == '0)));

  assert_full_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && !ack_i && !clr_i) |=> !empty_o);
endmodule

bind ppbuf_tx ppbuf_tx_chk #(.PKT_BYTES(PKT_BYTES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clr_i     (clr_i),
  .commit_i  (commit_i),
  .ack_i     (ack_i),
  .nak_i     (nak_i),
  .rd_valid_o(rd_valid_o),
  .rd_len_o  (rd_len_o),
  .rd_done_o (rd_done_o),
  .empty_o   (empty_o),
  .ovf_o     (ovf_o)
);

// File: tb/tb_ppbuf_tx.sv
module tb_ppbuf_tx;
  localparam int DW = 8;
  localparam int PB = 64;
  localparam int CW = $clog2(PB + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clr = 1'b0, wr_en = 1'b0, commit = 1'b0;
  logic          rd_en = 1'b0, ack = 1'b0, nak = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_valid, rd_done, empty, ovf;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] rd_len;

  int total = 0;
  int bad   = 0;
  bit fin   = 0;

  logic [DW-1:0] exp_q[$];
  int            len_q[$];
  logic [DW-1:0] cur[$];

  always #2 clk = ~clk;

  ppbuf_tx #(.DATA_W(DW), .PKT_BYTES(PB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .commit_i(commit), .rd_en_i(rd_en),
    .ack_i(ack), .nak_i(nak), .rd_valid_o(rd_valid), .rd_data_o(rd_data),
    .rd_len_o(rd_len), .rd_done_o(rd_done), .empty_o(empty), .ovf_o(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: all strobes set after a falling edge, taken at the next rising edge
  task automatic put(input logic [DW-1:0] b, input bit keep);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0;
    if (keep) exp_q.push_back(b);
  endtask

  task automatic seal(input int n, input bit keep);
    commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    if (keep) len_q.push_back(n);
  endtask

  task automatic put_seal(input logic [DW-1:0] b, input int n);
    wr_en = 1'b1; wr_data = b; commit = 1'b1;
    @(negedge clk); wr_en = 1'b0; commit = 1'b0;
    exp_q.push_back(b);
    len_q.push_back(n);
  endtask

  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic pulse_nak();
    nak = 1'b1; @(negedge clk); nak = 1'b0;
  endtask

  // monitor: pop the next expected packet and compare header
  task automatic fetch(input string req);
    int n;
    n = len_q.pop_front();
    cur.delete();
    for (int i = 0; i < n; i++) cur.push_back(exp_q.pop_front());
    chk(rd_valid === 1'b1, req, int'(rd_valid), 1);
    chk(int'(rd_len) == n, req, int'(rd_len), n);
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < cur.size(); i++) begin
      chk(rd_data === cur[i], req, int'(rd_data), int'(cur[i]));
      rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    end
    chk(rd_done === 1'b1, "R11 done after last byte", int'(rd_done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(empty === 1'b1, "R1 empty", int'(empty), 1);
    chk(rd_valid === 1'b0, "R1 valid", int'(rd_valid), 0);
    chk(ovf === 1'b0, "R1 ovf", int'(ovf), 0);

    // R2/R3/R5/R11: single packet, rewind, ack
    for (int i = 0; i < 5; i++) put(8'(8'h10 + i), 1'b1);
    seal(5, 1'b1);
    fetch("R2 single packet");
    read_all("R3 byte order");
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk(rd_done === 1'b1, "R11 extra read", int'(rd_done), 1);
    pulse_nak();
    chk(rd_done === 1'b0, "R5 rewind done", int'(rd_done), 0);
    chk(rd_data === cur[0], "R5 rewind first byte", int'(rd_data), int'(cur[0]));
    read_all("R5 replay");
    pulse_ack();
    chk(rd_valid === 1'b0, "R6 freed", int'(rd_valid), 0);
    chk(empty === 1'b1, "R6 empty", int'(empty), 1);

    // R4: zero-length packet
    seal(0, 1'b1);
    fetch("R4 zero length");
    chk(rd_done === 1'b1, "R4 done", int'(rd_done), 1);
    pulse_ack();

    // R7/R8: both halves sealed, drops ignored
    for (int i = 0; i < 3; i++) put(8'(8'hA0 + i), 1'b1);
    seal(3, 1'b1);
    chk(empty === 1'b1, "R8 one half free", int'(empty), 1);
    for (int i = 0; i < 3; i++) put(8'(8'hB0 + i), 1'b1);
    put_seal(8'hB3, 4);
    chk(empty === 1'b0, "R8 both sealed", int'(empty), 0);
    put(8'hEE, 1'b0);
    put(8'hEF, 1'b0);
    seal(2, 1'b0);
    chk(empty === 1'b0, "R8 still full", int'(empty), 0);
    fetch("R7 first sealed first");
    read_all("R7 first packet data");
    pulse_ack();
    chk(empty === 1'b1, "R8 empty after ack", int'(empty), 1);
    fetch("R2 write with commit");
    read_all("R8 second packet unchanged");
    pulse_ack();
    chk(rd_valid === 1'b0, "R8 dropped commit", int'(rd_valid), 0);

    // R9: overflow
    for (int i = 0; i < PB; i++) put(8'(i * 7 + 3), 1'b1);
    chk(ovf === 1'b0, "R9 no ovf at limit", int'(ovf), 0);
    put(8'h55, 1'b0);
    put(8'h66, 1'b0);
    chk(ovf === 1'b1, "R9 ovf set", int'(ovf), 1);
    seal(PB, 1'b1);
    fetch("R9 length capped");
    read_all("R9 data kept");
    pulse_ack();
    chk(ovf === 1'b1, "R9 ovf sticky", int'(ovf), 1);

    // R10: clear
    put(8'h01, 1'b0);
    seal(1, 1'b0);
    put(8'h02, 1'b0);
    seal(1, 1'b0);
    chk(empty === 1'b0, "R10 full before clear", int'(empty), 0);
    clr = 1'b1; @(negedge clk); clr = 1'b0;
    chk(rd_valid === 1'b0, "R10 valid", int'(rd_valid), 0);
    chk(empty === 1'b1, "R10 empty", int'(empty), 1);
    chk(ovf === 1'b0, "R10 ovf", int'(ovf), 0);
    put(8'hC1, 1'b1);
    put(8'hC2, 1'b1);
    seal(2, 1'b1);
    fetch("R10 after clear");
    read_all("R10 data after clear");
    pulse_ack();

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule